// File: doc/BRIEF.md
# Privileged Interrupt Selector with Machine Timer

This block decides, once per cycle, whether a hart with three privilege levels (user, supervisor, machine) must take an interrupt. If it must, the block also gives the cause number and the privilege level that handles it. Each clock edge registers the current privilege, the pending, enable and delegation masks, and the two global interrupt-enable bits. The decision is then formed combinationally from that registered state. Interrupts meant for a level above the current one are enabled implicitly. The delegation mask splits the candidates into a machine-level group and a supervisor-level group. The machine-level group is always tried first.

A 64-bit machine timer and its compare register sit inside the block. Both have simple write ports. The timer advances on a tick pulse, and on each tick the block re-evaluates whether the machine-timer interrupt is pending. That timer-pending flag takes the place of the timer bit of the pending mask input. The surrounding trap logic reads `take_irq_o`, `cause_o` and `target_priv_o` and performs the trap entry itself.

Top module: `irq_select_unit`

## Requirements
- R1: After reset, the block behaves as follows:
  - no interrupt is taken and the error flag is low;
  - the timer reads zero;
  - the compare register is all ones;
  - the timer-pending flag is clear.
- R2: The candidate set is the pending set ANDed with the enable mask. When the candidate set is zero, `take_irq_o` and `err_o` are both 0.
- R3: Machine-level candidates (delegation bit 0) are enabled when the registered privilege is not machine (encoding 3). At machine privilege they are enabled only when `mie_i` was 1.
- R4: Supervisor-level candidates (delegation bit 1) are enabled at user privilege (encoding 0) regardless of `sie_i`. At supervisor privilege (encoding 1) they are enabled only when `sie_i` is 1. At machine privilege they are never enabled.
- R5: `target_priv_o` is 3 when the interrupt comes from the machine-level group and 1 when it comes from the supervisor-level group.
- R6: The supervisor-level group is considered only when no machine-level decision is made. A decision is made when the machine group is enabled and non-empty.
- R7: Within the chosen group, a single cause is picked by fixed priority: 11, 3, 7, 9, 1, 5. The cause is output on `cause_o` as its 4-bit number. Bit n of each mask belongs to cause n.
- R8: Timer-pending behaviour:
  - On a cycle with `tick_i` high, the timer-pending flag becomes (compare <= timer) as an unsigned comparison, using the values held before that edge. A compare of zero therefore makes it pending.
  - Without a tick, the flag holds its value.
  - The flag replaces bit 7 of `pend_i`, and `pend_i[7]` is ignored.
- R9: Timer and compare updates:
  - The timer increments by one on each `tick_i` cycle.
  - A write via `time_we_i` loads `time_wdata_i` and takes precedence over the increment.
  - A write via `cmp_we_i` loads `cmp_wdata_i`.
- R10: When the chosen group is non-empty but contains no cause from the priority list, `err_o` is 1 and `take_irq_o` is 0. The supervisor-level group is then not considered.
- R11: The outputs reflect the inputs sampled at the previous rising clock edge, together with the timer-pending flag as updated at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| pend_i | input | NIRQ | Pending interrupt bits (bit 7 ignored) |
| en_i | input | NIRQ | Per-interrupt enable mask |
| deleg_i | input | NIRQ | Delegation mask, 1 sends a candidate to supervisor |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| tick_i | input | 1 | Timer advance pulse |
| time_we_i | input | 1 | Timer write enable |
| time_wdata_i | input | TW | Timer write data |
| cmp_we_i | input | 1 | Compare write enable |
| cmp_wdata_i | input | TW | Compare write data |
| take_irq_o | output | 1 | An interrupt must be taken |
| cause_o | output | 4 | Selected cause number |
| target_priv_o | output | 2 | Handling privilege: 3 machine, 1 supervisor |
| err_o | output | 1 | Non-empty group with no recognised cause |

## Verification
Two functions meet in one cycle: a tick that re-evaluates the timer compare, and a write to the compare or timer register. The bench writes the compare register during a tick. The expected result is that the flag follows the compare value held before the write, with the new value taking effect only from the next tick. A second overlap is the timer flag rising while a delegated supervisor interrupt is already being signalled. There, the scoreboard expects the machine timer to take over at once with target 3.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_M = 2'd3
  } priv_e;

  localparam int unsigned NUM_PRIO  = 6;
  localparam int unsigned CAUSE_W   = 4;
  localparam int unsigned MTI_BIT   = 7;
  localparam int unsigned MIN_NIRQ  = 12;

  // fixed priority, index 0 highest
  function automatic logic [CAUSE_W-1:0] prio_cause(input int unsigned idx);
    case (idx)
      0:       return 4'd11;
      1:       return 4'd3;
      2:       return 4'd7;
      3:       return 4'd9;
      4:       return 4'd1;
      default: return 4'd5;
    endcase
  endfunction

  typedef struct packed {
    logic [1:0] priv;
    logic       mie;
    logic       sie;
  } ctx_t;
endpackage

// File: rtl/irq_mtimer.sv
module irq_mtimer #(
  parameter int unsigned TW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          time_we_i,
  input  logic [TW-1:0] time_wdata_i,
  input  logic          cmp_we_i,
  input  logic [TW-1:0] cmp_wdata_i,
  output logic [TW-1:0] time_o,
  output logic [TW-1:0] cmp_o,
  output logic          mtip_o
);
  logic [TW-1:0] time_q, cmp_q;
  logic          mtip_q;
  logic          due;

  assign due = (cmp_q <= time_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
    end else if (time_we_i) begin
      time_q <= time_wdata_i;
    end else if (tick_i) begin
      time_q <= time_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '1;
    end else if (cmp_we_i) begin
      cmp_q <= cmp_wdata_i;
    end
  end

  // re-evaluated only on tick, against pre-edge values
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mtip_q <= 1'b0;
    end else if (tick_i) begin
      mtip_q <= due;
    end
  end

  assign time_o = time_q;
  assign cmp_o  = cmp_q;
  assign mtip_o = mtip_q;
endmodule

// File: rtl/irq_ctx_reg.sv
module irq_ctx_reg
  import irq_sel_pkg::*;
#(
  parameter int unsigned NIRQ = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      priv_i,
  input  logic [NIRQ-1:0] pend_i,
  input  logic [NIRQ-1:0] en_i,
  input  logic [NIRQ-1:0] deleg_i,
  input  logic            mie_i,
  input  logic            sie_i,
  output ctx_t            ctx_o,
  output logic [NIRQ-1:0] pend_o,
  output logic [NIRQ-1:0] en_o,
  output logic [NIRQ-1:0] deleg_o
);
  ctx_t            ctx_q;
  logic [NIRQ-1:0] pend_q, en_q, deleg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_q   <= '{priv: PRIV_M, mie: 1'b0, sie: 1'b0};
      pend_q  <= '0;
      en_q    <= '0;
      deleg_q <= '0;
    end else begin
      ctx_q   <= '{priv: priv_i, mie: mie_i, sie: sie_i};
      pend_q  <= pend_i;
      en_q    <= en_i;
      deleg_q <= deleg_i;
    end
  end

  assign ctx_o   = ctx_q;
  assign pend_o  = pend_q;
  assign en_o    = en_q;
  assign deleg_o = deleg_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_sel_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]         set_i,
  output logic                 hit_o,
  output logic [CAUSE_W-1:0]   cause_o
);
  always_comb begin
    hit_o   = 1'b0;
    cause_o = '0;
    // walk low to high priority, last match wins
    for (int i = NUM_PRIO - 1; i >= 0; i--) begin
      if (set_i[prio_cause(i)]) begin
        hit_o   = 1'b1;
        cause_o = prio_cause(i);
      end
    end
  end
endmodule

// File: rtl/irq_select_unit.sv
module irq_select_unit
  import irq_sel_pkg::*;
#(
  parameter int unsigned NIRQ = 16,
  parameter int unsigned TW   = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      priv_i,
  input  logic [NIRQ-1:0] pend_i,
  input  logic [NIRQ-1:0] en_i,
  input  logic [NIRQ-1:0] deleg_i,
  input  logic            mie_i,
  input  logic            sie_i,
  input  logic            tick_i,
  input  logic            time_we_i,
  input  logic [TW-1:0]   time_wdata_i,
  input  logic            cmp_we_i,
  input  logic [TW-1:0]   cmp_wdata_i,
  output logic            take_irq_o,
  output logic [3:0]      cause_o,
  output logic [1:0]      target_priv_o,
  output logic            err_o
);
  ctx_t            ctx;
  logic [NIRQ-1:0] pend_q, en_q, deleg_q;
  logic [NIRQ-1:0] pend_eff, cand, m_set, s_set;
  logic [TW-1:0]   time_q, cmp_q;
  logic            mtip_q;
  logic            m_en, s_en, m_hit, s_hit;
  logic [CAUSE_W-1:0] m_cause, s_cause;

  generate
    if (NIRQ < MIN_NIRQ) begin : g_bad_width
      initial $error("NIRQ must cover cause 11");
    end
  endgenerate

  irq_mtimer #(.TW(TW)) i_mtimer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .time_we_i    (time_we_i),
    .time_wdata_i (time_wdata_i),
    .cmp_we_i     (cmp_we_i),
    .cmp_wdata_i  (cmp_wdata_i),
    .time_o       (time_q),
    .cmp_o        (cmp_q),
    .mtip_o       (mtip_q)
  );

  irq_ctx_reg #(.NIRQ(NIRQ)) i_ctx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .priv_i  (priv_i),
    .pend_i  (pend_i),
    .en_i    (en_i),
    .deleg_i (deleg_i),
    .mie_i   (mie_i),
    .sie_i   (sie_i),
    .ctx_o   (ctx),
    .pend_o  (pend_q),
    .en_o    (en_q),
    .deleg_o (deleg_q)
  );

  always_comb begin
    pend_eff          = pend_q;
    pend_eff[MTI_BIT] = mtip_q;
  end

  assign cand  = pend_eff & en_q;
  assign m_set = cand & ~deleg_q;
  assign s_set = cand & deleg_q;

  // lower privilege implicitly enables the higher target
  assign m_en = (ctx.priv != PRIV_M) || ctx.mie;
  assign s_en = (ctx.priv == PRIV_U) || ((ctx.priv == PRIV_S) && ctx.sie);

  irq_prio_pick #(.W(NIRQ)) i_pick_m (
    .set_i   (m_set),
    .hit_o   (m_hit),
    .cause_o (m_cause)
  );

  irq_prio_pick #(.W(NIRQ)) i_pick_s (
    .set_i   (s_set),
    .hit_o   (s_hit),
    .cause_o (s_cause)
  );

  always_comb begin
    take_irq_o    = 1'b0;
    cause_o       = '0;
    target_priv_o = PRIV_U;
    err_o         = 1'b0;
    if (m_en && (m_set != '0)) begin
      take_irq_o    = m_hit;
      err_o         = !m_hit;
      cause_o       = m_hit ? m_cause : '0;
      target_priv_o = m_hit ? PRIV_M : PRIV_U;
    end else if (s_en && (s_set != '0)) begin
      take_irq_o    = s_hit;
      err_o         = !s_hit;
      cause_o       = s_hit ? s_cause : '0;
      target_priv_o = s_hit ? PRIV_S : PRIV_U;
    end
  end
endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk #(
  parameter int unsigned NIRQ = 16,
  parameter int unsigned TW   = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_i,
  input logic            time_we_i,
  input logic [1:0]      priv_i,
  input logic [NIRQ-1:0] en_i,
  input logic            take_irq_o,
  input logic [3:0]      cause_o,
  input logic [1:0]      target_priv_o,
  input logic            err_o,
  input logic [TW-1:0]   time_q,
  input logic            mtip_q
);
  AST_ERR_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !take_irq_o); // R10
  AST_TGT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |-> (target_priv_o == 2'd3 || target_priv_o == 2'd1)); // R5
  AST_S_NOT_AT_M: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_irq_o && target_priv_o == 2'd1) |-> ($past(priv_i) != 2'd3)); // R4
  AST_TAKE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |-> ($past(en_i) != '0)); // R2
  AST_CAUSE_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |-> (cause_o inside {4'd11, 4'd3, 4'd7, 4'd9, 4'd1, 4'd5})); // R7
  AST_TIME_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !time_we_i) |=> (time_q == $past(time_q) + 1'b1)); // R9
  AST_MTI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(mtip_q)); // R8
endmodule

bind irq_select_unit irq_select_chk #(.NIRQ(NIRQ), .TW(TW)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_i        (tick_i),
  .time_we_i     (time_we_i),
  .priv_i        (priv_i),
  .en_i          (en_i),
  .take_irq_o    (take_irq_o),
  .cause_o       (cause_o),
  .target_priv_o (target_priv_o),
  .err_o         (err_o),
  .time_q        (time_q),
  .mtip_q        (mtip_q)
);

// File: tb/test_irq_select_unit.sv
module test_irq_select_unit;
  localparam int unsigned NIRQ = 16;
  localparam int unsigned TW   = 64;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [1:0]      priv_i = 2'd3;
  logic [NIRQ-1:0] pend_i = '0, en_i = '0, deleg_i = '0;
  logic            mie_i = 1'b0, sie_i = 1'b0;
  logic            tick_i = 1'b0, time_we_i = 1'b0, cmp_we_i = 1'b0;
  logic [TW-1:0]   time_wdata_i = '0, cmp_wdata_i = '0;
  logic            take_irq_o, err_o;
  logic [3:0]      cause_o;
  logic [1:0]      target_priv_o;

  always #10 clk_i = ~clk_i;

  irq_select_unit #(.NIRQ(NIRQ), .TW(TW)) i_irq_select_unit (.*);

  typedef struct {
    logic       take;
    logic       err;
    logic [3:0] cause;
    logic [1:0] tgt;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;

  // bench model of the timer
  logic [TW-1:0] m_time = '0;
  logic [TW-1:0] m_cmp  = '1;
  logic          m_mti  = 1'b0;

  function automatic exp_t model(logic [1:0] pv, logic [NIRQ-1:0] pend, logic [NIRQ-1:0] en,
                                 logic [NIRQ-1:0] dg, logic mie, logic sie, logic mti);
    int ord[6] = '{11, 3, 7, 9, 1, 5};
    logic [NIRQ-1:0] p, c, ms, ss, grp;
    logic men, sen, use_grp;
    logic [1:0] t;
    exp_t r;
    r.take = 0; r.err = 0; r.cause = 0; r.tgt = 0; r.tag = "";
    p = pend; p[7] = mti;
    c = p & en; ms = c & ~dg; ss = c & dg;
    men = (pv != 2'd3) || mie;
    sen = (pv == 2'd0) || (pv == 2'd1 && sie);
    use_grp = 0; grp = '0; t = 0;
    if (men && ms != 0) begin use_grp = 1; grp = ms; t = 2'd3; end
    else if (sen && ss != 0) begin use_grp = 1; grp = ss; t = 2'd1; end
    if (use_grp) begin
      r.err = 1;
      for (int k = 0; k < 6; k++) begin
        if (r.err && grp[ord[k]]) begin
          r.err = 0; r.take = 1; r.cause = 4'(ord[k]); r.tgt = t;
        end
      end
    end
    return r;
  endfunction

  task automatic drive(input logic [1:0] pv, input logic [NIRQ-1:0] pend, input logic [NIRQ-1:0] en,
                       input logic [NIRQ-1:0] dg, input logic mie, input logic sie, input logic tick,
                       input logic twe, input logic [TW-1:0] twd, input logic cwe,
                       input logic [TW-1:0] cwd, input string tag);
    exp_t e;
    @(negedge clk_i);
    priv_i = pv; pend_i = pend; en_i = en; deleg_i = dg; mie_i = mie; sie_i = sie;
    tick_i = tick; time_we_i = twe; time_wdata_i = twd; cmp_we_i = cwe; cmp_wdata_i = cwd;
    if (tick) m_mti = (m_cmp <= m_time);
    if (twe) m_time = twd; else if (tick) m_time = m_time + 1'b1;
    if (cwe) m_cmp = cwd;
    e = model(pv, pend, en, dg, mie, sie, m_mti);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic irq(input logic [1:0] pv, input logic [NIRQ-1:0] pend, input logic [NIRQ-1:0] en,
                     input logic [NIRQ-1:0] dg, input logic mie, input logic sie, input string tag);
    drive(pv, pend, en, dg, mie, sie, 1'b0, 1'b0, '0, 1'b0, '0, tag);
  endtask

  task automatic tmr(input logic tick, input logic twe, input logic [TW-1:0] twd,
                     input logic cwe, input logic [TW-1:0] cwd, input string tag);
    drive(2'd0, 16'h0000, 16'h0080, 16'h0000, 1'b0, 1'b0, tick, twe, twd, cwe, cwd, tag);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(posedge clk_i);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (take_irq_o !== e.take || err_o !== e.err ||
            (e.take && (cause_o !== e.cause || target_priv_o !== e.tgt))) begin
          fails++;
          $display("FAIL %s: got take=%0b err=%0b cause=%0d tgt=%0d, exp take=%0b err=%0b cause=%0d tgt=%0d",
                   e.tag, take_irq_o, err_o, cause_o, target_priv_o, e.take, e.err, e.cause, e.tgt);
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired (all requirements): got hang, exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (take_irq_o !== 1'b0 || err_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 during reset: got take=%0b err=%0b, exp 0 0", take_irq_o, err_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (take_irq_o !== 1'b0 || err_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 after reset: got take=%0b err=%0b, exp 0 0", take_irq_o, err_o);
    end
    // R1: reset compare is all ones, so a tick at time 0 must not set pending
    tmr(1'b1, 1'b0, '0, 1'b0, '0, "R1 reset compare all ones");

    irq(2'd0, 16'hffff, 16'h0000, 16'h0000, 1, 1, "R2 nothing enabled");
    irq(2'd0, 16'h0000, 16'hffff, 16'h0000, 1, 1, "R2 nothing pending");
    irq(2'd3, 16'h0800, 16'h0800, 16'h0000, 0, 1, "R3 M priv mie=0 masked");
    irq(2'd3, 16'h0800, 16'h0800, 16'h0000, 1, 0, "R3 M priv mie=1 taken");
    irq(2'd1, 16'h0800, 16'h0800, 16'h0000, 0, 0, "R3 S priv implicit M enable");
    irq(2'd3, 16'h0002, 16'h0002, 16'h0002, 1, 1, "R4 S group never at M");
    irq(2'd1, 16'h0002, 16'h0002, 16'h0002, 1, 0, "R4 S priv sie=0 masked");
    irq(2'd1, 16'h0002, 16'h0002, 16'h0002, 0, 1, "R4 S priv sie=1 taken");
    irq(2'd0, 16'h0002, 16'h0002, 16'h0002, 0, 0, "R4 U priv implicit S enable");
    irq(2'd0, 16'h0208, 16'h0208, 16'h0200, 0, 0, "R5 R6 M group before S group");
    irq(2'd1, 16'h000a, 16'h000a, 16'h0002, 0, 1, "R6 machine MSI over delegated SSI");
    irq(2'd0, 16'h0222, 16'h0222, 16'h0222, 0, 0, "R5 delegated SEI targets S");
    irq(2'd0, 16'h0aaa, 16'hffff, 16'h0000, 0, 0, "R7 MEI highest");
    irq(2'd0, 16'h022a, 16'hffff, 16'h0000, 0, 0, "R7 MSI next");
    irq(2'd0, 16'h0222, 16'hffff, 16'h0000, 0, 0, "R7 SEI over SSI STI");
    irq(2'd0, 16'h0022, 16'hffff, 16'h0000, 0, 0, "R7 SSI over STI");
    irq(2'd0, 16'h0020, 16'hffff, 16'h0000, 0, 0, "R7 STI alone");
    irq(2'd0, 16'h2000, 16'h2000, 16'h0000, 0, 0, "R10 unrecognised bit error");
    irq(2'd0, 16'h2002, 16'h2002, 16'h0002, 0, 0, "R10 error blocks S group");
    irq(2'd0, 16'h0080, 16'h0080, 16'h0000, 0, 0, "R8 pend_i bit 7 ignored");

    // timer
    tmr(1'b0, 1'b0, '0, 1'b1, 64'd0, "R8 compare write without tick");
    tmr(1'b1, 1'b0, '0, 1'b0, '0, "R8 zero compare pending on tick");
    tmr(1'b0, 1'b0, '0, 1'b0, '0, "R8 flag holds without tick");
    tmr(1'b1, 1'b0, '0, 1'b1, '1, "R8 tick uses old compare in write cycle");
    tmr(1'b1, 1'b0, '0, 1'b0, '0, "R8 new compare clears on next tick");
    tmr(1'b0, 1'b1, 64'd5, 1'b1, 64'd8, "R9 load timer and compare");
    for (int i = 0; i < 4; i++) tmr(1'b1, 1'b0, '0, 1'b0, '0, "R9 increment to equal compare");
    // timer pending and MSI both machine-level: MSI wins
    drive(2'd0, 16'h0008, 16'h0088, 16'h0000, 0, 0, 1'b0, 1'b0, '0, 1'b0, '0, "R7 MSI over MTI");
    drive(2'd0, 16'h0202, 16'h0282, 16'h0202, 0, 0, 1'b0, 1'b0, '0, 1'b0, '0, "R6 MTI preempts delegated");
    tmr(1'b0, 1'b1, 64'h7fff_ffff_ffff_ffff, 1'b1, 64'h8000_0000_0000_0000, "R9 load wide values");
    tmr(1'b1, 1'b0, '0, 1'b0, '0, "R8 unsigned compare not due");
    tmr(1'b1, 1'b0, '0, 1'b0, '0, "R8 unsigned compare due at equal");
    irq(2'd3, 16'h0800, 16'h0800, 16'h0000, 0, 0, "R11 latched mie=0");

    while (q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
    finish_run();
  end
endmodule